// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a byte-organized serial EEPROM that a host reaches over three wires: a select line, a serial clock and a data input. It answers on a data output whose drive enable is a separate port. The pins are sampled by the system clock, and a rising serial clock edge is found inside the block. Every instruction frame has the same front part: a start bit, a two-bit command code and a nine-bit word address. Reads stream bytes back one after another for as long as the host keeps clocking. Programming commands are held until the select line falls, and they run only if the write-enable latch is set.

After a programming step starts, the block holds a busy interval that lasts a parameterized number of system clocks. During that interval it ignores new instructions. Whenever the host raises select again, the block drives its progress on the data output: low while busy, high once done. The array is an internal register file and is cleared to zero on reset.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the data output is not driven (do_oe_o = 0), every array byte reads 0x00 and the write-enable latch is clear.
- R2: Bits sampled on rising serial clock edges while select is high are ignored until the first 1, which is the start bit. The start bit is followed by a 2-bit command (10 read, 01 write, 11 erase one byte, 00 extended) and a 9-bit address sent MSB first. For the extended command the two top address bits pick 11 enable-writes, 00 disable-writes, 10 fill-with-ones or 01 fill-with-data, and the other address bits are ignored.
- R3: On the edge that samples the last address bit of a read, the output drives a single 0 bit. Each later edge drives the next bit of the addressed byte, MSB first.
- R4: After the eighth data bit of a byte, a read continues with the following address, and address 511 is followed by address 0.
- R5: While the write-enable latch is clear (after reset or after disable-writes), write, erase and both fill commands leave the array unchanged and start no busy interval.
- R6: A write stores its 8 data bits (sent MSB first after the address) when select falls. Edges after the 20th edge of the frame are ignored.
- R7: If select falls before a programming frame is complete, nothing is changed and no busy interval starts.
- R8: An erase sets the addressed byte to 0xFF.
- R9: Fill-with-ones sets every byte to 0xFF. Fill-with-data writes the supplied byte into every location.
- R10: Once a programming step has started, raising select makes the output drive 0 while busy and 1 when ready, and this can be polled repeatedly. The output is undriven when select is low.
- R11: Frames sent while the busy interval runs are ignored.
- R12: Dropping select during a read or an unfinished frame returns the block to idle with the output undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_i | input | 1 | Device select, active high |
| sk_i | input | 1 | Serial clock from the host |
| di_i | input | 1 | Serial data from the host |
| do_o | output | 1 | Serial data or ready/busy status |
| do_oe_o | output | 1 | Drive enable for do_o |

## Verification
The assertions assume that the serial clock and select change slowly compared with the system clock, so that every serial edge and every select change is seen by at least two system clocks before the next one. They also assume that select stays low for several system clocks between frames. The bench drives each serial phase for three system clocks and holds select low for six. Inputs change only on the falling system edge, and outputs are sampled three clocks after each serial edge, after the sampling stage and the state register have both settled.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SB,
        ST_HDR,
        ST_DATA,
        ST_READ,
        ST_ARMED
    } st_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_WRITE,
        ACT_ERASE,
        ACT_FILL1,
        ACT_FILLD,
        ACT_WEN,
        ACT_WDIS
    } act_e;

    localparam logic [1:0] CMD_READ  = 2'b10;
    localparam logic [1:0] CMD_WRITE = 2'b01;
    localparam logic [1:0] CMD_ERASE = 2'b11;
    localparam logic [1:0] CMD_EXT   = 2'b00;

    localparam logic [1:0] SUB_WEN   = 2'b11;
    localparam logic [1:0] SUB_FILL1 = 2'b10;
    localparam logic [1:0] SUB_FILLD = 2'b01;
    localparam logic [1:0] SUB_WDIS  = 2'b00;

endpackage

// File: rtl/eep3w_pin_sample.sv
module eep3w_pin_sample (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic cs_q_o,
    output logic di_q_o,
    output logic sk_rise_o
);
    logic cs_q, sk_q, di_q, sk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q      <= 1'b0;
            sk_q      <= 1'b0;
            di_q      <= 1'b0;
            sk_prev_q <= 1'b0;
        end else begin
            cs_q      <= cs_i;
            sk_q      <= sk_i;
            di_q      <= di_i;
            sk_prev_q <= sk_q;
        end
    end

    assign cs_q_o    = cs_q;
    assign di_q_o    = di_q;
    assign sk_rise_o = sk_q & ~sk_prev_q;
endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              fill_en_i,
    input  logic [DATA_W-1:0] fill_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        logic hit;
        assign hit = wr_en_i && (wr_addr_i == ADDR_W'(g));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else if (fill_en_i) begin
                word_q[g] <= fill_data_i;
            end else if (hit) begin
                word_q[g] <= wr_data_i;
            end
        end
    end

    assign rd_data_o = word_q[rd_addr_i];
endmodule

// File: rtl/eep3w_busy_timer.sv
module eep3w_busy_timer #(
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(BUSY_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CW'(BUSY_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sk_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    import eep3w_pkg::*;

    localparam int HDR_W  = 2 + ADDR_W;
    localparam int CNT_MX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
    localparam int CNT_W  = $clog2(CNT_MX + 1);
    localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] HDR_LAST = CNT_W'(HDR_W - 1);
    localparam logic [CNT_W-1:0] DAT_LAST = CNT_W'(DATA_W - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    typedef struct packed {
        st_e               st;
        logic [HDR_W-1:0]  hdr;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [BIT_W-1:0]  bitx;
        act_e              act;
        logic              wen;
        logic              status;
        logic              oe;
        logic              dval;
    } regs_t;

    regs_t r_q, r_d;

    logic              cs_q, di_q, sk_rise;
    logic              busy_w;
    logic              prog_start;
    logic              wr_en, fill_en;
    logic [DATA_W-1:0] wr_data, fill_data;
    logic [DATA_W-1:0] rd_data;
    logic [HDR_W-1:0]  full_hdr;
    logic [1:0]        cmd;
    logic [ADDR_W-1:0] hdr_addr;
    logic [1:0]        sub;

    eep3w_pin_sample u_pins (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_i      (cs_i),
        .sk_i      (sk_i),
        .di_i      (di_i),
        .cs_q_o    (cs_q),
        .di_q_o    (di_q),
        .sk_rise_o (sk_rise)
    );

    eep3w_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en_i     (wr_en),
        .wr_addr_i   (r_q.addr),
        .wr_data_i   (wr_data),
        .fill_en_i   (fill_en),
        .fill_data_i (fill_data),
        .rd_addr_i   (r_q.addr),
        .rd_data_o   (rd_data)
    );

    eep3w_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (prog_start),
        .busy_o  (busy_w)
    );

    assign full_hdr = {r_q.hdr[HDR_W-2:0], di_q};
    assign cmd      = full_hdr[HDR_W-1 -: 2];
    assign hdr_addr = full_hdr[ADDR_W-1:0];
    assign sub      = hdr_addr[ADDR_W-1 -: 2];

    always_comb begin
        r_d        = r_q;
        prog_start = 1'b0;
        wr_en      = 1'b0;
        fill_en    = 1'b0;
        wr_data    = r_q.data;
        fill_data  = r_q.data;

        unique case (r_q.st)
            ST_IDLE: begin
                if (cs_q && !busy_w) r_d.st = ST_WAIT_SB;
            end

            ST_WAIT_SB: begin
                if (!cs_q) begin
                    r_d.st = ST_IDLE;
                end else if (sk_rise && di_q) begin
                    r_d.st     = ST_HDR;
                    r_d.cnt    = '0;
                    r_d.status = 1'b0;
                end
            end

            ST_HDR: begin
                if (!cs_q) begin
                    r_d.st = ST_IDLE;
                end else if (sk_rise) begin
                    r_d.hdr = full_hdr;
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == HDR_LAST) begin
                        r_d.addr = hdr_addr;
                        r_d.cnt  = '0;
                        r_d.act  = ACT_NONE;
                        unique case (cmd)
                            CMD_READ: begin
                                r_d.st   = ST_READ;
                                r_d.bitx = '0;
                                r_d.dval = 1'b0;
                            end
                            CMD_WRITE: begin
                                r_d.st  = ST_DATA;
                                r_d.act = ACT_WRITE;
                            end
                            CMD_ERASE: begin
                                r_d.st  = ST_ARMED;
                                r_d.act = ACT_ERASE;
                            end
                            default: begin
                                unique case (sub)
                                    SUB_WEN: begin
                                        r_d.st  = ST_ARMED;
                                        r_d.act = ACT_WEN;
                                    end
                                    SUB_FILL1: begin
                                        r_d.st  = ST_ARMED;
                                        r_d.act = ACT_FILL1;
                                    end
                                    SUB_FILLD: begin
                                        r_d.st  = ST_DATA;
                                        r_d.act = ACT_FILLD;
                                    end
                                    default: begin
                                        r_d.st  = ST_ARMED;
                                        r_d.act = ACT_WDIS;
                                    end
                                endcase
                            end
                        endcase
                    end
                end
            end

            ST_DATA: begin
                if (!cs_q) begin
                    r_d.st = ST_IDLE;
                end else if (sk_rise) begin
                    r_d.data = {r_q.data[DATA_W-2:0], di_q};
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (r_q.cnt == DAT_LAST) r_d.st = ST_ARMED;
                end
            end

            ST_READ: begin
                if (!cs_q) begin
                    r_d.st = ST_IDLE;
                end else if (sk_rise) begin
                    r_d.dval = rd_data[BIT_LAST - r_q.bitx];
                    r_d.bitx = r_q.bitx + 1'b1;
                    if (r_q.bitx == BIT_LAST) begin
                        r_d.bitx = '0;
                        r_d.addr = r_q.addr + 1'b1;
                    end
                end
            end

            ST_ARMED: begin
                if (!cs_q) begin
                    r_d.st = ST_IDLE;
                    unique case (r_q.act)
                        ACT_WEN:  r_d.wen = 1'b1;
                        ACT_WDIS: r_d.wen = 1'b0;
                        ACT_WRITE: begin
                            wr_en      = r_q.wen;
                            prog_start = r_q.wen;
                        end
                        ACT_ERASE: begin
                            wr_en      = r_q.wen;
                            wr_data    = '1;
                            prog_start = r_q.wen;
                        end
                        ACT_FILL1: begin
                            fill_en    = r_q.wen;
                            fill_data  = '1;
                            prog_start = r_q.wen;
                        end
                        ACT_FILLD: begin
                            fill_en    = r_q.wen;
                            prog_start = r_q.wen;
                        end
                        default: ;
                    endcase
                    if (prog_start) r_d.status = 1'b1;
                end
            end

            default: r_d.st = ST_IDLE;
        endcase

        if (r_d.st == ST_READ) begin
            r_d.oe = 1'b1;
        end else if (cs_q && r_d.status &&
                     (r_d.st == ST_IDLE || r_d.st == ST_WAIT_SB)) begin
            r_d.oe   = 1'b1;
            r_d.dval = ~busy_w;
        end else begin
            r_d.oe   = 1'b0;
            r_d.dval = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, act: ACT_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign do_o    = r_q.dval;
    assign do_oe_o = r_q.oe;
endmodule

// File: rtl/eep3w_chk.sv
module eep3w_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_i,
    input logic do_o,
    input logic do_oe_o,
    input logic busy,
    input logic prog_start,
    input logic wen
);
    logic [1:0] low_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             low_cnt_q <= '0;
        else if (cs_i)          low_cnt_q <= '0;
        else if (low_cnt_q != 2'd3) low_cnt_q <= low_cnt_q + 1'b1;
    end

    p_quiet_deselected_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (low_cnt_q == 2'd3) |-> !do_oe_o);

    p_prog_needs_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> wen);

    p_busy_from_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(prog_start));

    p_no_start_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !prog_start);

    p_status_low_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (do_oe_o && busy && $past(busy)) |=> (!do_oe_o || !do_o));
endmodule

bind eep3w_slave eep3w_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_i       (cs_i),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o),
    .busy       (busy_w),
    .prog_start (prog_start),
    .wen        (r_q.wen)
);

// File: tb/eep3w_slave_tb.sv
module eep3w_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int BUSY       = 400;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, di = 1'b0;
    logic dout, doe;

    int n_chk = 0;
    int n_fail = 0;
    int cs_low_run = 0;
    logic [7:0] mem_m [512];
    logic wen_m = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eep3w_slave #(.ADDR_W(9), .DATA_W(8), .BUSY_CYCLES(BUSY)) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_i    (cs),
        .sk_i    (sk),
        .di_i    (di),
        .do_o    (dout),
        .do_oe_o (doe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R10 / R12: output undriven whenever select has been low a while
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs) cs_low_run++;
            else     cs_low_run = 0;
            if (cs_low_run >= 4) check("R12 undriven when deselected", {7'd0, doe}, 8'd0);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bit_out(input logic b);
        sk = 1'b0;
        di = b;
        tick(3);
        sk = 1'b1;
        tick(3);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) bit_out(v[i]);
    endtask

    task automatic deselect();
        sk = 1'b0;
        tick(2);
        cs = 1'b0;
        di = 1'b0;
        tick(6);
    endtask

    task automatic frame(input logic [1:0] opc, input logic [8:0] a, input int lead0);
        cs = 1'b1;
        tick(2);
        send(16'd0, lead0);
        bit_out(1'b1);
        send({14'd0, opc}, 2);
        send({7'd0, a}, 9);
    endtask

    task automatic poll(input string tag, input logic exp_ready);
        cs = 1'b1;
        tick(4);
        check({tag, " status drive"}, {7'd0, doe}, 8'd1);
        check({tag, " status value"}, {7'd0, dout}, {7'd0, exp_ready});
        cs = 1'b0;
        tick(6);
    endtask

    task automatic rd(input string tag, input logic [8:0] a0, input int nbytes);
        int a;
        logic [7:0] e;
        a = a0;
        frame(2'b10, a0, 0);
        check({tag, " R3 dummy drive"}, {7'd0, doe}, 8'd1);
        check({tag, " R3 dummy zero"}, {7'd0, dout}, 8'd0);
        for (int k = 0; k < nbytes; k++) begin
            e = mem_m[a];
            for (int b = 7; b >= 0; b--) begin
                bit_out(1'b0);
                check({tag, " R3 R4 data bit"}, {7'd0, dout}, {7'd0, e[b]});
            end
            a = (a + 1) % 512;
        end
        deselect();
        check({tag, " R12 released"}, {7'd0, doe}, 8'd0);
    endtask

    // control frames: sub-code in top address bits
    task automatic ctrl(input logic [1:0] sc);
        frame(2'b00, {sc, 7'd0}, 0);
        deselect();
        wen_m = (sc == 2'b11) ? 1'b1 : (sc == 2'b00) ? 1'b0 : wen_m;
    endtask

    task automatic wait_ready();
        tick(BUSY + 20);
    endtask

    task automatic wr(input logic [8:0] a, input logic [7:0] d, input int extra);
        frame(2'b01, a, 0);
        send({8'd0, d}, 8);
        send(16'h5555, extra);
        deselect();
        if (wen_m) mem_m[a] = d;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h00;
        tick(4);
        rst_n = 1'b1;
        tick(4);
        check("R1 reset output undriven", {7'd0, doe}, 8'd0);

        // R5: write before enable has no effect
        wr(9'd5, 8'h77, 0);
        rd("R1 R5 write while disabled", 9'd5, 1);

        // R2: leading zeros before the start bit, enable writes
        frame(2'b00, 9'h180, 3);
        deselect();
        wen_m = 1'b1;

        // R6: write with extra trailing bits
        wr(9'd5, 8'hA5, 3);
        poll("R10 busy poll", 1'b0);
        poll("R10 busy repoll", 1'b0);
        // R11: frame while busy is ignored
        wr(9'd6, 8'h11, 0);
        mem_m[6] = 8'h00;
        wait_ready();
        poll("R10 ready poll", 1'b1);
        poll("R10 ready repoll", 1'b1);
        rd("R6 R11 after write", 9'd5, 2);

        // R7: truncated write
        frame(2'b01, 9'd7, 0);
        send(16'h1F, 5);
        deselect();
        rd("R7 truncated", 9'd7, 1);

        // R8: erase
        frame(2'b11, 9'd7, 0);
        deselect();
        mem_m[7] = 8'hFF;
        poll("R8 erase busy", 1'b0);
        wait_ready();
        rd("R8 erase", 9'd6, 2);

        // R4: wrap at end of array
        wr(9'd511, 8'h3C, 0);
        wait_ready();
        wr(9'd0, 8'hC3, 0);
        wait_ready();
        rd("R4 wrap", 9'd511, 2);

        // R12: abandon read mid-frame
        frame(2'b10, 9'd5, 0);
        bit_out(1'b0);
        bit_out(1'b0);
        deselect();
        check("R12 abandoned read", {7'd0, doe}, 8'd0);
        cs = 1'b1;
        tick(2);
        send(16'h3, 3);
        deselect();
        check("R12 abandoned header", {7'd0, doe}, 8'd0);

        // R5: disable then write
        ctrl(2'b00);
        wr(9'd9, 8'h99, 0);
        rd("R5 after disable", 9'd9, 1);

        // R9: fill with data, then fill with ones
        ctrl(2'b11);
        frame(2'b00, 9'h080, 0);
        send(16'h5A, 8);
        deselect();
        for (int i = 0; i < 512; i++) mem_m[i] = 8'h5A;
        wait_ready();
        rd("R9 fill data", 9'd0, 3);
        rd("R9 fill data tail", 9'd510, 3);
        frame(2'b00, 9'h100, 0);
        deselect();
        for (int i = 0; i < 512; i++) mem_m[i] = 8'hFF;
        wait_ready();
        rd("R9 fill ones", 9'd100, 3);

        finish_run();
    end
endmodule